// File: doc/BRIEF.md
# Interrupt source state controller

This block keeps the per-input state for a bank of interrupt sources and feeds them, one at a time, to a single downstream presenter. Every source is fixed at build time as either level-sensitive or message-type. Each source holds a target server, a priority and a saved priority. A priority of all ones means the source is masked. Sources are identified on the presenter side by a global interrupt number, which is the local index plus a fixed base.

Level sources follow the input level. They keep an asserted/sent pair, so a held level is delivered once and is offered again only after the presenter gives it back through a reject or an end-of-interrupt followed by a resend. Message sources react to single-cycle pulses. A pulse that arrives while the source is masked is remembered and replayed when a configuration write unmasks the source. A message source that the presenter turns down is marked rejected and waits for a resend.

The presenter sends notifications (reject, end-of-interrupt, resend) that carry an interrupt number. A resend walks the sources one per cycle. Work found during the walk is queued per source and offered once the single outstanding request slot is free.

Top module: `src_ctl`

## Requirements
- R1: After reset no request is offered, and every source is masked: priority and saved priority are all ones and the server is zero, so a message pulse after reset is not presented.
- R2: An unmasked message source that sees a one-cycle high on its `src_i` bit is offered with `req_num_o` equal to `NUM_BASE` plus its index, together with its current server, priority and saved priority.
- R3: A message pulse that arrives while the source is masked is recorded. A later configuration write with a priority other than all ones presents that source once.
- R4: An unmasked level source whose input rises is offered once and marked sent. While it stays high it is not offered again. An end-of-interrupt (`ntf_op_i` = 1) clears the sent mark without re-offering the source, and a later resend (`ntf_op_i` = 2) offers it again.
- R5: A reject (`ntf_op_i` = 0) of a message source marks it rejected, and it is not offered again until a resend, which clears the mark and re-offers it.
- R6: A reject of a level source clears its sent mark. A later resend re-offers it only if its input is still high.
- R7: An end-of-interrupt on a message source has no effect, so a following resend offers nothing.
- R8: At most one request is outstanding. While `req_valid_o` is high and `req_ready_i` is low, number, server and priority hold. When several sources are queued, the lowest index is offered first.
- R9: Notifications whose number lies outside `NUM_BASE` to `NUM_BASE+NUM_SRC-1` change no source.
- R10: A notification selects the source whose index is its number minus `NUM_BASE`, and every offered number lies in that range.
- R11: A handshake completed with `req_rej_i` high counts as a reject of the offered source.
- R12: A configuration write that unmasks a level source whose input is high and not yet sent offers it.
- R13: A masked source is never offered, so `req_prio_o` is never all ones while `req_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Source inputs: levels for level sources, one-cycle pulses for message sources |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Local index of the source being configured |
| cfg_srv_i | input | SRV_W | Target server to write |
| cfg_prio_i | input | PRIO_W | Priority to write (all ones masks the source) |
| cfg_sprio_i | input | PRIO_W | Saved priority to write |
| ntf_valid_i | input | 1 | Notification strobe |
| ntf_op_i | input | 2 | Notification kind: 0 reject, 1 end-of-interrupt, 2 resend, 3 none |
| ntf_num_i | input | NUM_W | Global interrupt number for reject and end-of-interrupt |
| req_valid_o | output | 1 | Presentation request pending |
| req_ready_i | input | 1 | Presenter answers the pending request |
| req_rej_i | input | 1 | Answer is a reject (sampled with req_ready_i) |
| req_num_o | output | NUM_W | Global interrupt number being presented |
| req_srv_o | output | SRV_W | Target server of the request |
| req_prio_o | output | PRIO_W | Priority of the request |
| req_sprio_o | output | PRIO_W | Saved priority of the presented source |

## Verification
The case that needs care is a handshake that rejects the offered message source in the same cycle as a resend notification. If the reject lands before the scan reaches that source, the scan should clear the mark and offer the source again. The bench drives `req_ready_i`, `req_rej_i` and a resend notification in the same cycle and expects the same interrupt number to come back. A second coincidence is two message pulses arriving together. It is judged by checking that the lower index is presented first and that its fields stay frozen while the presenter stalls.

// File: rtl/srcctl_pkg.sv
package srcctl_pkg;

  localparam logic [1:0] OP_REJ    = 2'd0;
  localparam logic [1:0] OP_EOI    = 2'd1;
  localparam logic [1:0] OP_RESEND = 2'd2;

  typedef struct packed {
    logic asserted;
    logic sent;
    logic rejected;
    logic mpend;
    logic queued;
  } src_stat_t;

endpackage

// File: rtl/srcctl_slot.sv
module srcctl_slot
  import srcctl_pkg::*;
#(
  parameter bit IS_LVL = 1'b0,
  parameter int SRV_W  = 4,
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_i,
  input  logic              issue_i,
  input  logic              rej_i,
  input  logic              eoi_i,
  input  logic              scan_i,
  input  logic              cfg_we_i,
  input  logic [SRV_W-1:0]  cfg_srv_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic [PRIO_W-1:0] cfg_sprio_i,
  output logic              elig_o,
  output logic [SRV_W-1:0]  srv_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [PRIO_W-1:0] sprio_o
);

  src_stat_t         st_q, st_d;
  logic [SRV_W-1:0]  srv_q, srv_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic [PRIO_W-1:0] sprio_q, sprio_d;
  logic              unm;
  logic              rise;

  // order inside a cycle: issue, config, reject/eoi, scan, input event
  always_comb begin
    st_d    = st_q;
    srv_d   = srv_q;
    prio_d  = prio_q;
    sprio_d = sprio_q;
    rise    = 1'b0;
    if (issue_i) st_d.queued = 1'b0;
    if (cfg_we_i) begin
      srv_d   = cfg_srv_i;
      prio_d  = cfg_prio_i;
      sprio_d = cfg_sprio_i;
    end
    unm = (prio_d != '1);
    if (IS_LVL) begin
      if (rej_i || eoi_i) st_d.sent = 1'b0;
      rise          = in_i && !st_q.asserted;
      st_d.asserted = in_i;
      if ((rise || scan_i || cfg_we_i) && unm && in_i && !st_d.sent) begin
        st_d.sent   = 1'b1;
        st_d.queued = 1'b1;
      end
    end else begin
      if (rej_i) st_d.rejected = 1'b1;
      if (scan_i && st_d.rejected) begin
        st_d.rejected = 1'b0;
        if (unm) st_d.queued = 1'b1;
      end
      if (in_i) begin
        if (unm) st_d.queued = 1'b1;
        else     st_d.mpend  = 1'b1;
      end
      if (cfg_we_i && st_d.mpend && unm) begin
        st_d.mpend  = 1'b0;
        st_d.queued = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= '0;
      srv_q   <= '0;
      prio_q  <= '1;
      sprio_q <= '1;
    end else begin
      st_q    <= st_d;
      srv_q   <= srv_d;
      prio_q  <= prio_d;
      sprio_q <= sprio_d;
    end
  end

  assign elig_o  = st_q.queued && (prio_q != '1);
  assign srv_o   = srv_q;
  assign prio_o  = prio_q;
  assign sprio_o = sprio_q;

endmodule

// File: rtl/srcctl_pick.sv
module srcctl_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        any_o = 1'b1;
        idx_o = IW'(k);
      end
    end
  end

endmodule

// File: rtl/srcctl_scan.sv
module srcctl_scan #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  output logic [N-1:0] hit_o
);

  logic          on_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      idx_q <= '0;
    end else if (start_i) begin
      on_q  <= 1'b1;
      idx_q <= '0;
    end else if (on_q) begin
      if (idx_q == IW'(N - 1)) on_q <= 1'b0;
      else                     idx_q <= idx_q + 1'b1;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_hit
    assign hit_o[k] = on_q && (idx_q == IW'(k));
  end

endmodule

// File: rtl/src_ctl.sv
module src_ctl
  import srcctl_pkg::*;
#(
  parameter int                 NUM_SRC  = 8,
  parameter int                 NUM_BASE = 16,
  parameter int                 NUM_W    = 8,
  parameter int                 SRV_W    = 4,
  parameter int                 PRIO_W   = 8,
  parameter logic [NUM_SRC-1:0] LVL_MASK = 'hF0,
  localparam int                IDX_W    = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [SRV_W-1:0]   cfg_srv_i,
  input  logic [PRIO_W-1:0]  cfg_prio_i,
  input  logic [PRIO_W-1:0]  cfg_sprio_i,
  input  logic               ntf_valid_i,
  input  logic [1:0]         ntf_op_i,
  input  logic [NUM_W-1:0]   ntf_num_i,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  input  logic               req_rej_i,
  output logic [NUM_W-1:0]   req_num_o,
  output logic [SRV_W-1:0]   req_srv_o,
  output logic [PRIO_W-1:0]  req_prio_o,
  output logic [PRIO_W-1:0]  req_sprio_o
);

  logic               ntf_rej, ntf_eoi, ntf_rs, hs;
  logic [NUM_SRC-1:0] rej_v, eoi_v, cfg_v, iss_v, scan_v, elig_v;
  logic [SRV_W-1:0]   srv_a   [NUM_SRC];
  logic [PRIO_W-1:0]  prio_a  [NUM_SRC];
  logic [PRIO_W-1:0]  sprio_a [NUM_SRC];
  logic               pick_any;
  logic [IDX_W-1:0]   pick_idx;

  logic               valid_q;
  logic [IDX_W-1:0]   idx_q;
  logic [NUM_W-1:0]   num_q;
  logic [SRV_W-1:0]   srv_q;
  logic [PRIO_W-1:0]  prio_q, sprio_q;

  assign ntf_rej = ntf_valid_i && (ntf_op_i == OP_REJ);
  assign ntf_eoi = ntf_valid_i && (ntf_op_i == OP_EOI);
  assign ntf_rs  = ntf_valid_i && (ntf_op_i == OP_RESEND);
  assign hs      = valid_q && req_ready_i;

  srcctl_scan #(.N(NUM_SRC), .IW(IDX_W)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(ntf_rs),
    .hit_o  (scan_v)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic num_hit;
    // exact match on the global number doubles as the range check
    assign num_hit  = (ntf_num_i == NUM_W'(NUM_BASE + k));
    assign rej_v[k] = (ntf_rej && num_hit) ||
                      (hs && req_rej_i && (idx_q == IDX_W'(k)));
    assign eoi_v[k] = ntf_eoi && num_hit;
    assign cfg_v[k] = cfg_we_i && (cfg_idx_i == IDX_W'(k));
    assign iss_v[k] = !valid_q && pick_any && (pick_idx == IDX_W'(k));

    srcctl_slot #(
      .IS_LVL(LVL_MASK[k]),
      .SRV_W (SRV_W),
      .PRIO_W(PRIO_W)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_i       (src_i[k]),
      .issue_i    (iss_v[k]),
      .rej_i      (rej_v[k]),
      .eoi_i      (eoi_v[k]),
      .scan_i     (scan_v[k]),
      .cfg_we_i   (cfg_v[k]),
      .cfg_srv_i  (cfg_srv_i),
      .cfg_prio_i (cfg_prio_i),
      .cfg_sprio_i(cfg_sprio_i),
      .elig_o     (elig_v[k]),
      .srv_o      (srv_a[k]),
      .prio_o     (prio_a[k]),
      .sprio_o    (sprio_a[k])
    );
  end

  srcctl_pick #(.N(NUM_SRC), .IW(IDX_W)) u_pick (
    .req_i(elig_v),
    .any_o(pick_any),
    .idx_o(pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      num_q   <= '0;
      srv_q   <= '0;
      prio_q  <= '0;
      sprio_q <= '0;
    end else if (hs) begin
      valid_q <= 1'b0;
    end else if (!valid_q && pick_any) begin
      valid_q <= 1'b1;
      idx_q   <= pick_idx;
      num_q   <= NUM_W'(NUM_BASE) + NUM_W'(pick_idx);
      srv_q   <= srv_a[pick_idx];
      prio_q  <= prio_a[pick_idx];
      sprio_q <= sprio_a[pick_idx];
    end
  end

  assign req_valid_o = valid_q;
  assign req_num_o   = num_q;
  assign req_srv_o   = srv_q;
  assign req_prio_o  = prio_q;
  assign req_sprio_o = sprio_q;

endmodule

// File: rtl/srcctl_chk.sv
module srcctl_chk #(
  parameter int NUM_SRC  = 8,
  parameter int NUM_BASE = 16,
  parameter int NUM_W    = 8,
  parameter int SRV_W    = 4,
  parameter int PRIO_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [NUM_W-1:0]  req_num_o,
  input logic [SRV_W-1:0]  req_srv_o,
  input logic [PRIO_W-1:0] req_prio_o
);

  // R13
  masked_never_offered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_prio_o != '1));

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_num_o) && $stable(req_srv_o) && $stable(req_prio_o)));

  // R8
  single_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> !req_valid_o);

  // R10
  num_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> ((int'(req_num_o) >= NUM_BASE) && (int'(req_num_o) < NUM_BASE + NUM_SRC)));

endmodule

bind src_ctl srcctl_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_BASE(NUM_BASE),
  .NUM_W   (NUM_W),
  .SRV_W   (SRV_W),
  .PRIO_W  (PRIO_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i),
  .req_num_o  (req_num_o),
  .req_srv_o  (req_srv_o),
  .req_prio_o (req_prio_o)
);

// File: tb/sim_src_ctl.sv
module sim_src_ctl;

  localparam int N  = 8;
  localparam int NB = 16;
  localparam int NW = 8;
  localparam int SW = 4;
  localparam int PW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src;
  logic          cfg_we;
  logic [IW-1:0] cfg_idx;
  logic [SW-1:0] cfg_srv;
  logic [PW-1:0] cfg_prio, cfg_sprio;
  logic          ntf_v;
  logic [1:0]    ntf_op;
  logic [NW-1:0] ntf_num;
  logic          req_valid, req_ready, req_rej;
  logic [NW-1:0] req_num;
  logic [SW-1:0] req_srv;
  logic [PW-1:0] req_prio, req_sprio;

  int errs   = 0;
  int checks = 0;

  always #4 clk = ~clk;

  src_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_srv_i(cfg_srv),
    .cfg_prio_i(cfg_prio), .cfg_sprio_i(cfg_sprio),
    .ntf_valid_i(ntf_v), .ntf_op_i(ntf_op), .ntf_num_i(ntf_num),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_rej_i(req_rej),
    .req_num_o(req_num), .req_srv_o(req_srv), .req_prio_o(req_prio),
    .req_sprio_o(req_sprio)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic expect_req(input string tag, input int num, input int srv,
                            input int prio, input int sprio, input bit rej);
    int w = 0;
    while (!req_valid && w < 24) begin
      @(negedge clk);
      w++;
    end
    chk(req_valid, {tag, " valid"}, int'(req_valid), 1);
    if (req_valid) begin
      chk(int'(req_num) == num, {tag, " num"}, int'(req_num), num);
      chk(int'(req_srv) == srv, {tag, " srv"}, int'(req_srv), srv);
      chk(int'(req_prio) == prio && int'(req_sprio) == sprio, {tag, " prio"},
          int'(req_prio), prio);
      req_ready = 1'b1;
      req_rej   = rej;
      @(negedge clk);
      req_ready = 1'b0;
      req_rej   = 1'b0;
    end
  endtask

  task automatic expect_none(input string tag, input int n);
    bit seen = 1'b0;
    int num  = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (req_valid) begin
        seen = 1'b1;
        num  = int'(req_num);
      end
    end
    chk(!seen, {tag, " no request"}, num, 0);
  endtask

  task automatic pulse(input int idx);
    src[idx] = 1'b1;
    @(negedge clk);
    src[idx] = 1'b0;
  endtask

  task automatic cfg(input int idx, input int srv, input int prio, input int sprio);
    cfg_we    = 1'b1;
    cfg_idx   = IW'(idx);
    cfg_srv   = SW'(srv);
    cfg_prio  = PW'(prio);
    cfg_sprio = PW'(sprio);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ntf(input int op, input int num);
    ntf_v   = 1'b1;
    ntf_op  = 2'(op);
    ntf_num = NW'(num);
    @(negedge clk);
    ntf_v = 1'b0;
  endtask

  task automatic t_reset();
    chk(!req_valid, "R1 idle after reset", int'(req_valid), 0);
    pulse(0);
    expect_none("R1 msi masked by reset", 10);
    cfg(0, 3, 5, 9);
    expect_req("R3 masked pulse replay", 16, 3, 5, 9, 1'b0);
    expect_none("R3 replay once", 8);
  endtask

  task automatic t_msi();
    cfg(1, 2, 4, 4);
    pulse(1);
    expect_req("R2 msi present", 17, 2, 4, 4, 1'b0);
    expect_none("R2 single delivery", 8);
  endtask

  task automatic t_level();
    cfg(4, 1, 6, 6);
    expect_none("R4 low level idle", 5);
    src[4] = 1'b1;
    expect_req("R4 level present", 20, 1, 6, 6, 1'b0);
    expect_none("R4 held level once", 10);
    ntf(1, 20);
    expect_none("R4 eoi no replay", 10);
    ntf(2, 0);
    expect_req("R4 resend after eoi", 20, 1, 6, 6, 1'b0);
    src[4] = 1'b0;
    @(negedge clk);
    ntf(1, 20);
  endtask

  task automatic t_reject_msi();
    int w = 0;
    pulse(1);
    while (!req_valid && w < 24) begin
      @(negedge clk);
      w++;
    end
    chk(req_valid && int'(req_num) == 17, "R11 offer before reject", int'(req_num), 17);
    // handshake reject coinciding with a resend notification
    req_ready = 1'b1;
    req_rej   = 1'b1;
    ntf_v     = 1'b1;
    ntf_op    = 2'd2;
    ntf_num   = '0;
    @(negedge clk);
    req_ready = 1'b0;
    req_rej   = 1'b0;
    ntf_v     = 1'b0;
    expect_req("R11 R5 reject then resend", 17, 2, 4, 4, 1'b0);
    pulse(1);
    expect_req("R5 offer", 17, 2, 4, 4, 1'b0);
    ntf(0, 17);
    expect_none("R5 rejected waits", 12);
    ntf(2, 0);
    expect_req("R5 R10 resend replays", 17, 2, 4, 4, 1'b0);
  endtask

  task automatic t_reject_lvl();
    cfg(5, 7, 7, 7);
    src[5] = 1'b1;
    expect_req("R6 level offer", 21, 7, 7, 7, 1'b0);
    ntf(0, 21);
    expect_none("R6 reject waits", 10);
    ntf(2, 0);
    expect_req("R6 resend asserted", 21, 7, 7, 7, 1'b0);
    ntf(0, 21);
    src[5] = 1'b0;
    @(negedge clk);
    ntf(2, 0);
    expect_none("R6 resend deasserted", 15);
  endtask

  task automatic t_eoi_msi();
    pulse(1);
    expect_req("R7 offer", 17, 2, 4, 4, 1'b0);
    ntf(1, 17);
    ntf(2, 0);
    expect_none("R7 eoi ignored by msi", 15);
  endtask

  task automatic t_range();
    pulse(0);
    expect_req("R9 offer", 16, 3, 5, 9, 1'b0);
    ntf(0, 24);
    ntf(0, 8);
    ntf(2, 0);
    expect_none("R9 out of range reject ignored", 15);
  endtask

  task automatic t_order();
    int w = 0;
    cfg(2, 5, 3, 3);
    cfg(3, 6, 2, 2);
    src[2] = 1'b1;
    src[3] = 1'b1;
    @(negedge clk);
    src[2] = 1'b0;
    src[3] = 1'b0;
    while (!req_valid && w < 24) begin
      @(negedge clk);
      w++;
    end
    repeat (3) @(negedge clk);
    chk(req_valid && int'(req_num) == 18, "R8 held while stalled", int'(req_num), 18);
    expect_req("R8 lowest first", 18, 5, 3, 3, 1'b0);
    expect_req("R8 second", 19, 6, 2, 2, 1'b0);
  endtask

  task automatic t_cfg_lvl();
    src[6] = 1'b1;
    src[7] = 1'b1;
    expect_none("R13 masked level silent", 10);
    cfg(6, 2, 1, 1);
    expect_req("R12 unmask level", 22, 2, 1, 1, 1'b0);
    expect_none("R13 other still masked", 10);
    src[6] = 1'b0;
    src[7] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    src       = '0;
    cfg_we    = 1'b0;
    cfg_idx   = '0;
    cfg_srv   = '0;
    cfg_prio  = '0;
    cfg_sprio = '0;
    ntf_v     = 1'b0;
    ntf_op    = 2'd3;
    ntf_num   = '0;
    req_ready = 1'b0;
    req_rej   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_msi();
    t_level();
    t_reject_msi();
    t_reject_lvl();
    t_eoi_msi();
    t_range();
    t_order();
    t_cfg_lvl();
    finish_run();
  end

endmodule